// File: doc/BRIEF.md
# One-Time-Programmable Fuse Bank Controller

This block fronts an emulated bank of one-time-programmable fuses. The bank has three registers: a 256-bit secret key, a 14-bit protection word and a 32-bit user word. A host drives a bit-serial command port. Each command is either a program operation or a read operation aimed at one register. Programming can only set bits, so new data is ORed into what is already stored. The protection word holds active-high lock fuses, and the controller enforces them: some of them hide a register from the port, and some of them freeze registers against further programming. The key fuses and the low byte of the user word are burned in a single operation, and a second attempt at either one is refused.

Logic beside the block can always read the user word through a parallel output. The two policy bits of the protection word also drive two outputs: one forces use of the fuse key, and one blocks partial reconfiguration from external ports. A synchronous reset models a fresh, blank part. It clears every fuse and the error flag.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Fuse storage only accumulates ones. An accepted program ORs the shifted data into the target register, so a program of zeros leaves bits that are already set unchanged. After reset every register reads zero.
- R2: A key program shifts 264 bits on `sdi`, taking one bit on each cycle where `sdi_en` is high. The first 256 bits are key bits 255 down to 0. The last 8 bits are user bits 0 up to 7. A key read returns key bit 255 first.
- R3: Program and read of the protection word (14 bits) and of the user word (32 bits) move bit 0 first.
- R4: When protection bit 2 is set, programs of the key and of the user word are refused.
- R5: When protection bit 3 is set, a key read returns all zeros, and programs of the key and of the user word are refused.
- R6: When protection bit 4 is set, a port read of the user word returns all zeros, and programs of the key and of the user word are refused. `user_word` still shows the stored value.
- R7: When protection bit 5 is set, programs of the protection word are refused.
- R8: A key program is refused once the key or user bits [7:0] hold any one. A user program that carries a one in bits [7:0] is refused once the key holds any one.
- R9: A refused program leaves every fuse unchanged. A refused program, a read that returns zeros because of a lock, and a command with select value 3 all set `err`, which stays set until reset.
- R10: `force_fuse_key` follows protection bit 0 and `ext_partial_block` follows protection bit 1.
- R11: A read is accepted at a clock edge. `sdo_vld` stays low for one cycle and then stays high for exactly as many cycles as the register has bits, one bit per cycle. After the last data bit of a program, the register updates on the second rising edge, and `busy` falls at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; blanks all fuses |
| cmd_go | input | 1 | Command strobe, taken while `busy` is low |
| cmd_wr | input | 1 | 1 = program, 0 = read |
| cmd_sel | input | 2 | 0 = key, 1 = protection word, 2 = user word, 3 = invalid |
| sdi | input | 1 | Serial program data |
| sdi_en | input | 1 | Qualifies `sdi` for the current cycle |
| sdo | output | 1 | Serial read data |
| sdo_vld | output | 1 | `sdo` carries a read bit |
| busy | output | 1 | A command is in progress |
| err | output | 1 | Sticky refusal flag |
| user_word | output | USER_W | Parallel user word for the fabric |
| force_fuse_key | output | 1 | Protection bit 0 |
| ext_partial_block | output | 1 | Protection bit 1 |

## Verification
Read data timing is checked at falling edges. On the first falling edge after the accept edge, the bench expects `sdo_vld` low and `busy` high. It then expects one valid bit at each of the following falling edges, and after the last bit it expects `sdo_vld` and `busy` both low. For programs, the bench samples `user_word` and `busy` at the falling edge after the last data bit and again one cycle later: the first sample must show the old contents, the second the new ones. Bit streams include idle gaps on `sdi_en` to confirm that only qualified cycles count. A sweep over all sixteen lock combinations computes each expected read value, output value and error flag from the rules above.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_USER = 2'd2,
    SEL_NONE = 2'd3
  } fuse_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT_IN,
    ST_COMMIT,
    ST_SHIFT_OUT
  } seq_state_e;

  // protection-word bit positions (behavioural, decoded across the bank)
  localparam int CB_FORCE_KEY  = 0;
  localparam int CB_NO_PARTIAL = 1;
  localparam int CB_PROG_LOCK  = 2;
  localparam int CB_KEY_HIDE   = 3;
  localparam int CB_USER_HIDE  = 4;
  localparam int CB_CTRL_LOCK  = 5;

endpackage

// File: rtl/otp_policy.sv
module otp_policy
  import otp_fuse_pkg::*;
(
  input  logic       wr,
  input  logic [1:0] sel,
  input  logic [3:0] locks,        // protection bits 5..2
  input  logic       key_any,      // key already holds a one
  input  logic       link_any,     // user[7:0] already holds a one
  input  logic       new_link_any, // incoming user[7:0] carries a one
  output logic       deny
);

  logic prog_lock, key_hide, user_hide, ctrl_lock, kv_frozen;

  always_comb begin
    prog_lock = locks[CB_PROG_LOCK - 2];
    key_hide  = locks[CB_KEY_HIDE  - 2];
    user_hide = locks[CB_USER_HIDE - 2];
    ctrl_lock = locks[CB_CTRL_LOCK - 2];
    // any of the three key/user locks freezes both registers
    kv_frozen = prog_lock | key_hide | user_hide;
    deny = 1'b1;
    if (wr) begin
      case (fuse_sel_e'(sel))
        SEL_KEY:  deny = kv_frozen | key_any | link_any;
        SEL_USER: deny = kv_frozen | (key_any & new_link_any);
        SEL_CTRL: deny = ctrl_lock;
        default:  deny = 1'b1;
      endcase
    end else begin
      case (fuse_sel_e'(sel))
        SEL_KEY:  deny = key_hide;
        SEL_USER: deny = user_hide;
        SEL_CTRL: deny = 1'b0;
        default:  deny = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_fuse_pkg::*;
#(
  parameter int KEY_W  = 256,
  parameter int CTRL_W = 14,
  parameter int USER_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [CTRL_W-1:0] wr_ctrl,
  input  logic [USER_W-1:0] wr_user,
  output logic [KEY_W-1:0]  key_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [USER_W-1:0] user_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= '0;
      ctrl_q <= '0;
      user_q <= '0;
    end else if (wr_en) begin
      case (fuse_sel_e'(wr_sel))
        SEL_KEY: begin
          key_q  <= key_q  | wr_key;
          user_q <= user_q | wr_user;   // low byte burned with the key
        end
        SEL_CTRL: ctrl_q <= ctrl_q | wr_ctrl;
        SEL_USER: user_q <= user_q | wr_user;
        default: ;
      endcase
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_fuse_monotone_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    ((key_q & $past(key_q)) == $past(key_q)) &&
    ((ctrl_q & $past(ctrl_q)) == $past(ctrl_q)) &&
    ((user_q & $past(user_q)) == $past(user_q)))
    else $error("fuse bit cleared");

  assert_prog_lock_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(ctrl_q[CB_PROG_LOCK]) |-> ($stable(key_q) && $stable(user_q)))
    else $error("key/user changed under program lock");

  assert_key_hide_lock_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(ctrl_q[CB_KEY_HIDE]) |-> ($stable(key_q) && $stable(user_q)))
    else $error("key/user changed under key hide");

  assert_user_hide_lock_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(ctrl_q[CB_USER_HIDE]) |-> ($stable(key_q) && $stable(user_q)))
    else $error("key/user changed under user hide");

  assert_ctrl_lock_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(ctrl_q[CB_CTRL_LOCK]) |-> $stable(ctrl_q))
    else $error("protection word changed under lock");

endmodule

// File: rtl/otp_serial.sv
module otp_serial
  import otp_fuse_pkg::*;
#(
  parameter int KEY_W  = 256,
  parameter int CTRL_W = 14,
  parameter int USER_W = 32,
  parameter int LINK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_sel,
  input  logic              sdi,
  input  logic              sdi_en,
  input  logic [KEY_W-1:0]  key_q,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic [USER_W-1:0] user_q,
  input  logic              deny,
  output logic              pol_wr,
  output logic [1:0]        pol_sel,
  output logic              new_link_any,
  output logic              wr_en,
  output logic [1:0]        wr_sel,
  output logic [KEY_W-1:0]  stg_key,
  output logic [CTRL_W-1:0] stg_ctrl,
  output logic [USER_W-1:0] stg_user,
  output logic              sdo,
  output logic              sdo_vld,
  output logic              busy,
  output logic              err
);

  localparam int MAXLEN = KEY_W + LINK_W;
  localparam int CW     = $clog2(MAXLEN + 1);
  localparam int KIW    = $clog2(KEY_W);
  localparam int CIW    = $clog2(CTRL_W);
  localparam int UIW    = $clog2(USER_W);

  seq_state_e      state;
  fuse_sel_e       op_sel;
  logic            op_wr, op_deny;
  logic [CW-1:0]   cnt, op_last;
  logic [KIW-1:0]  key_idx;
  logic [CIW-1:0]  ctrl_idx;
  logic [UIW-1:0]  user_idx, link_idx;
  logic            out_bit;

  function automatic logic [CW-1:0] last_of(input logic wr, input fuse_sel_e s);
    case (s)
      SEL_KEY:  return wr ? CW'(MAXLEN - 1) : CW'(KEY_W - 1);
      SEL_CTRL: return CW'(CTRL_W - 1);
      default:  return CW'(USER_W - 1);
    endcase
  endfunction

  always_comb begin
    key_idx  = KIW'(CW'(KEY_W - 1) - cnt);   // key moves top bit first
    link_idx = UIW'(cnt - CW'(KEY_W));       // trailing user low byte
    ctrl_idx = CIW'(cnt);
    user_idx = UIW'(cnt);
    case (op_sel)
      SEL_KEY:  out_bit = key_q[key_idx];
      SEL_CTRL: out_bit = ctrl_q[ctrl_idx];
      default:  out_bit = user_q[user_idx];
    endcase
  end

  assign pol_wr       = (state == ST_IDLE) ? cmd_wr  : op_wr;
  assign pol_sel      = (state == ST_IDLE) ? cmd_sel : op_sel;
  assign new_link_any = |stg_user[LINK_W-1:0];
  assign wr_en        = (state == ST_COMMIT) && !deny;
  assign wr_sel       = op_sel;
  assign busy         = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_sel   <= SEL_KEY;
      op_wr    <= 1'b0;
      op_deny  <= 1'b0;
      op_last  <= '0;
      cnt      <= '0;
      stg_key  <= '0;
      stg_ctrl <= '0;
      stg_user <= '0;
      sdo      <= 1'b0;
      sdo_vld  <= 1'b0;
      err      <= 1'b0;
    end else begin
      sdo     <= 1'b0;
      sdo_vld <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_go) begin
            if (fuse_sel_e'(cmd_sel) == SEL_NONE) begin
              err <= 1'b1;
            end else begin
              op_sel   <= fuse_sel_e'(cmd_sel);
              op_wr    <= cmd_wr;
              op_last  <= last_of(cmd_wr, fuse_sel_e'(cmd_sel));
              op_deny  <= !cmd_wr && deny;
              cnt      <= '0;
              stg_key  <= '0;
              stg_ctrl <= '0;
              stg_user <= '0;
              if (!cmd_wr && deny) err <= 1'b1;
              state <= cmd_wr ? ST_SHIFT_IN : ST_SHIFT_OUT;
            end
          end
        end
        ST_SHIFT_IN: begin
          if (sdi_en) begin
            case (op_sel)
              SEL_KEY: begin
                if (cnt < CW'(KEY_W)) stg_key[key_idx]  <= sdi;
                else                  stg_user[link_idx] <= sdi;
              end
              SEL_CTRL: stg_ctrl[ctrl_idx] <= sdi;
              default:  stg_user[user_idx] <= sdi;
            endcase
            cnt <= cnt + 1'b1;
            if (cnt == op_last) state <= ST_COMMIT;
          end
        end
        ST_COMMIT: begin
          if (deny) err <= 1'b1;
          state <= ST_IDLE;
        end
        ST_SHIFT_OUT: begin
          sdo     <= !op_deny && out_bit;
          sdo_vld <= 1'b1;
          cnt     <= cnt + 1'b1;
          if (cnt == op_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(err) |-> err)
    else $error("error flag dropped");

  assert_key_masked_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    (sdo_vld && op_sel == SEL_KEY && ctrl_q[CB_KEY_HIDE]) |-> !sdo)
    else $error("hidden key leaked");

  assert_user_masked_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    (sdo_vld && op_sel == SEL_USER && ctrl_q[CB_USER_HIDE]) |-> !sdo)
    else $error("hidden user word leaked");

  assert_out_only_reading_R11: assert property (@(posedge clk) disable iff (rst || !armed)
    sdo_vld |-> ($past(state) == ST_SHIFT_OUT))
    else $error("read data outside a read");

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int KEY_W  = 256,
  parameter int CTRL_W = 14,
  parameter int USER_W = 32,
  parameter int LINK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_sel,
  input  logic              sdi,
  input  logic              sdi_en,
  output logic              sdo,
  output logic              sdo_vld,
  output logic              busy,
  output logic              err,
  output logic [USER_W-1:0] user_word,
  output logic              force_fuse_key,
  output logic              ext_partial_block
);

  logic [KEY_W-1:0]  key_q, stg_key;
  logic [CTRL_W-1:0] ctrl_q, stg_ctrl;
  logic [USER_W-1:0] user_q, stg_user;
  logic              pol_wr, new_link_any, deny, wr_en;
  logic [1:0]        pol_sel, wr_sel;

  otp_serial #(
    .KEY_W(KEY_W), .CTRL_W(CTRL_W), .USER_W(USER_W), .LINK_W(LINK_W)
  ) u_serial (
    .clk(clk), .rst(rst),
    .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
    .sdi(sdi), .sdi_en(sdi_en),
    .key_q(key_q), .ctrl_q(ctrl_q), .user_q(user_q),
    .deny(deny),
    .pol_wr(pol_wr), .pol_sel(pol_sel), .new_link_any(new_link_any),
    .wr_en(wr_en), .wr_sel(wr_sel),
    .stg_key(stg_key), .stg_ctrl(stg_ctrl), .stg_user(stg_user),
    .sdo(sdo), .sdo_vld(sdo_vld), .busy(busy), .err(err)
  );

  otp_policy u_policy (
    .wr(pol_wr), .sel(pol_sel),
    .locks(ctrl_q[CB_CTRL_LOCK:CB_PROG_LOCK]),
    .key_any(|key_q),
    .link_any(|user_q[LINK_W-1:0]),
    .new_link_any(new_link_any),
    .deny(deny)
  );

  otp_store #(
    .KEY_W(KEY_W), .CTRL_W(CTRL_W), .USER_W(USER_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_key(stg_key), .wr_ctrl(stg_ctrl), .wr_user(stg_user),
    .key_q(key_q), .ctrl_q(ctrl_q), .user_q(user_q)
  );

  assign user_word         = user_q;
  assign force_fuse_key    = ctrl_q[CB_FORCE_KEY];
  assign ext_partial_block = ctrl_q[CB_NO_PARTIAL];

endmodule

// File: tb/otp_fuse_ctrl_test.sv
module otp_fuse_ctrl_test;

  localparam int KW = 256;
  localparam int CW = 14;
  localparam int UW = 32;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_go = 1'b0, cmd_wr = 1'b0;
  logic [1:0]    cmd_sel = 2'd0;
  logic          sdi = 1'b0, sdi_en = 1'b0;
  logic          sdo, sdo_vld, busy, err;
  logic [UW-1:0] user_word;
  logic          force_fuse_key, ext_partial_block;

  otp_fuse_ctrl uut (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
    .sdi(sdi), .sdi_en(sdi_en), .sdo(sdo), .sdo_vld(sdo_vld), .busy(busy),
    .err(err), .user_word(user_word), .force_fuse_key(force_fuse_key),
    .ext_partial_block(ext_partial_block)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [UW-1:0] snap_a, snap_b;
  logic busy_a, busy_b;

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic issue(input bit wr, input logic [1:0] sel);
    cmd_go = 1'b1; cmd_wr = wr; cmd_sel = sel;
    @(posedge clk); @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic send_bit(input bit b, input int i);
    if (i % 7 == 3) begin
      sdi_en = 1'b0; sdi = ~b;
      @(posedge clk); @(negedge clk);
    end
    sdi = b; sdi_en = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_prog();
    sdi_en = 1'b0;
    snap_a = user_word; busy_a = busy;
    @(negedge clk);
    snap_b = user_word; busy_b = busy;
  endtask

  task automatic prog_key(input logic [255:0] k, input logic [7:0] lo);
    issue(1'b1, 2'd0);
    for (int i = 0; i < KW; i++) send_bit(k[KW-1-i], i);
    for (int i = 0; i < LW; i++) send_bit(lo[i], KW + i);
    finish_prog();
  endtask

  task automatic prog_word(input logic [1:0] sel, input logic [31:0] w, input int n);
    issue(1'b1, sel);
    for (int i = 0; i < n; i++) send_bit(w[i], i);
    finish_prog();
  endtask

  task automatic read_reg(input logic [1:0] sel, input int n, output logic [255:0] v);
    bit tm_ok;
    v = '0;
    issue(1'b0, sel);
    tm_ok = (sdo_vld == 1'b0) && (busy == 1'b1);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (!sdo_vld) tm_ok = 1'b0;
      if (sel == 2'd0) v[n-1-i] = sdo;
      else             v[i] = sdo;
      @(negedge clk);
    end
    if (sdo_vld || busy) tm_ok = 1'b0;
    check("R11 read timing", tm_ok, 1'b1);
  endtask

  function automatic logic [255:0] key_pat(input int seed);
    logic [255:0] k;
    for (int i = 0; i < 8; i++) k[i*32 +: 32] = 32'h9E37_79B9 * 32'(i + 1) + 32'(seed);
    return k;
  endfunction

  initial begin
    logic [255:0] rv;
    @(negedge clk);

    // sweep every combination of lock bits 5..2
    for (int m = 0; m < 16; m++) begin
      logic [13:0]   p, ctl_e;
      logic [255:0]  k, key_e;
      logic [UW-1:0] usr_e, usr_old, u;
      logic [7:0]    lo;
      bit c3, c4, c5, kv_lock, errx;
      p = 14'(m << 2) | 14'(m & 3);
      c3 = p[3]; c4 = p[4]; c5 = p[5];
      kv_lock = p[2] | p[3] | p[4];
      errx = 1'b0; key_e = '0; usr_e = '0; ctl_e = '0;
      k = key_pat(m);
      lo = 8'h3C + 8'(m);

      do_reset();
      check("R1 blank user word after reset", user_word, 0);
      check("R9 err clear after reset", err, 0);
      check("R11 idle after reset", busy, 0);

      prog_word(2'd1, 32'(p), CW);
      ctl_e = p;
      check("R10 policy outputs", {ext_partial_block, force_fuse_key}, p[1:0]);
      check("R9 no err on first protection program", err, 0);

      prog_key(k, lo);
      if (!kv_lock) begin key_e = k; usr_e[7:0] = lo; end
      else errx = 1'b1;
      check(kv_lock ? "R4 R5 R6 key program refused" : "R2 key program accepted", err, errx);
      check("R6 fabric user word", user_word, usr_e);

      read_reg(2'd0, KW, rv);
      if (c3) errx = 1'b1;
      check(c3 ? "R5 hidden key reads zero" : "R2 key readback order", rv, c3 ? 256'd0 : key_e);

      read_reg(2'd2, UW, rv);
      if (c4) errx = 1'b1;
      check(c4 ? "R6 hidden user reads zero" : "R3 user readback", rv, c4 ? 256'd0 : 256'(usr_e));
      check("R9 sticky err after reads", err, errx);

      u = 32'h5A00_0000 | (32'(m) << 12);
      usr_old = usr_e;
      prog_word(2'd2, u, UW);
      if (!kv_lock) usr_e = usr_e | u;
      else errx = 1'b1;
      check("R11 user word before commit edge", snap_a, usr_old);
      check("R11 user word after commit edge", snap_b, usr_e);
      check("R11 busy around commit", {busy_a, busy_b}, 2'b10);
      check(kv_lock ? "R4 user program refused" : "R1 user program ORed", err, errx);

      prog_word(2'd1, 32'h0041, CW);
      if (!c5) ctl_e = ctl_e | 14'h0041;
      else errx = 1'b1;
      read_reg(2'd1, CW, rv);
      check(c5 ? "R7 protection word frozen" : "R3 protection word readback", rv, 256'(ctl_e));
      check("R10 force output follows bit 0", force_fuse_key, ctl_e[0]);
      check("R9 err after protection program", err, errx);
    end

    // R1: ones accumulate, zeros never clear
    do_reset();
    prog_word(2'd2, 32'h0000_F0F0, UW);
    prog_word(2'd2, 32'h0000_0F0F, UW);
    check("R1 OR accumulate", user_word, 32'h0000_FFFF);
    prog_word(2'd2, 32'h0000_0000, UW);
    check("R1 zeros keep set bits", user_word, 32'h0000_FFFF);
    read_reg(2'd2, UW, rv);
    check("R3 user port read", rv, 256'h0000_FFFF);
    check("R1 no err on accumulate", err, 0);

    // R3: bit 0 first on the user word
    do_reset();
    prog_word(2'd2, 32'h0000_0001, UW);
    check("R3 user bit 0 shifted first", user_word, 32'h0000_0001);

    // R8: user low byte first, then key refused
    do_reset();
    prog_word(2'd2, 32'h0000_00A5, UW);
    prog_key(key_pat(99), 8'h00);
    check("R8 key refused after user low byte", err, 1);
    read_reg(2'd0, KW, rv);
    check("R8 key unchanged after refusal", rv, 0);
    check("R9 user unchanged after refusal", user_word, 32'h0000_00A5);

    // R8: key first, then user low byte refused, high bits still allowed
    do_reset();
    prog_key(key_pat(7), 8'h00);
    check("R8 key with empty low byte accepted", err, 0);
    prog_word(2'd2, 32'h0000_0001, UW);
    check("R8 user low byte refused after key", err, 1);
    check("R8 user word unchanged", user_word, 0);
    prog_word(2'd2, 32'h0100_0000, UW);
    check("R8 user high bits allowed after key", user_word, 32'h0100_0000);

    // R8: second key program refused
    do_reset();
    prog_key(key_pat(3), 8'h77);
    check("R2 low byte burned with key", user_word, 32'h0000_0077);
    prog_key(key_pat(4), 8'h00);
    check("R8 second key refused", err, 1);
    read_reg(2'd0, KW, rv);
    check("R8 key keeps first value", rv, key_pat(3));

    // R9: invalid select
    do_reset();
    issue(1'b0, 2'd3);
    check("R9 invalid select not started", busy, 0);
    check("R9 invalid select flags err", err, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (120000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule